// File: doc/BRIEF.md
# SDRAM Burst and Latency Engine

This block is the device-side read and write datapath of a synchronous DRAM bank model. A decoded command arrives each clock. A mode-load command stores a control word. That word sets the burst length, whether writes burst or touch a single location, and the read latency in clocks. A read or write command starts a column counter. The counter walks the burst in sequential order inside an aligned block and presents one column address per cycle to the memory array.

On the read side, the array's read data passes through a latency pipeline. The data therefore appears on the data outputs a fixed number of clocks after the command. The output enable rises one clock ahead of the first valid word. On the write side, the word present on the data input at each burst edge goes to the array at that beat's column. A read or write issued at any cycle, including in the middle of a burst, restarts the counter at once. Read data that is already in the pipeline still leaves at the latency it was issued with.

Top module: `sdb_engine`

## Requirements
- R1: After reset the counter is idle, `dq_oe` is low, `dq_out` is zero and `mode_reserved` is low. The active mode is burst length 1, write bursting enabled and latency 3.
- R2: `cmd` is encoded as 0 = no operation, 1 = read, 2 = write and 3 = mode load. Bits 2:0 of the mode word select the burst length: 0→1, 1→2, 2→4, 3→8, 7→full page (all 512 columns).
- R3: A burst of 2, 4 or 8 visits the columns of the aligned block that holds the start column. It goes in ascending order, wraps to the block base, and covers each column once.
- R4: A full-page burst steps through the columns, wraps from 511 to 0, and keeps running until another read or write command arrives.
- R5: When mode bit 9 is 1, a write touches only its start column, while reads still use the programmed burst length. When bit 9 is 0, writes use the burst length.
- R6: `mode_reserved` is high after a load in which any of these holds: bits 8:7 are nonzero, the latency field (bits 6:4) is not 1, 2 or 3, or the burst field is 4, 5 or 6. A reserved burst field acts as length 1, and a reserved latency acts as 3.
- R7: For a read registered at edge n with latency CL, beat k is shown on `dq_out` in the cycle that follows edge n+CL+k.
- R8: `dq_oe` is high from the cycle after edge n+CL−1 until the last beat's data cycle ends. It then drops, unless a later read keeps data flowing.
- R9: A read or write command is accepted on any cycle and replaces the running burst at once. Reads issued on back-to-back cycles keep their own latency, with no gap on `dq_out`.
- R10: During a write beat `arr_we` is high, `arr_addr` is that beat's column, and `arr_wdata` is the `dq_in` value that was present at the edge that began the beat.
- R11: `dq_out` is zero in every cycle that carries no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Decoded command |
| cmd_col | input | 9 | Start column for read or write |
| mode_word | input | 12 | Control word stored on mode load |
| arr_addr | output | 9 | Column being accessed this cycle |
| arr_we | output | 1 | Array write strobe |
| arr_wdata | output | 32 | Array write data |
| arr_rdata | input | 32 | Array read data for `arr_addr` |
| dq_in | input | 32 | Write data from the bus |
| dq_out | output | 32 | Read data to the bus |
| dq_oe | output | 1 | Data output enable |
| col_busy | output | 1 | A burst is running |
| mode_reserved | output | 1 | Last stored mode word holds a reserved setting |

## Verification
The bench builds the block with its default parameters. These are a 9-bit column, a 32-bit word and a latency pipe three stages deep. With them, every latency setting, every fixed burst length and the wrap of a full page past column 511 can all be reached within a few hundred cycles. A behavioural model steps alongside the design each clock. Each cycle it compares the address, write strobe, write data, output enable and read data. This covers back-to-back reads under latency 1, a write then read-back, interrupted full-page bursts and reserved mode words.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_MODE  = 2'd3
  } sdb_cmd_e;

  // Field positions inside the mode word
  localparam int BL_LSB   = 0;
  localparam int CL_LSB   = 4;
  localparam int OPM_LSB  = 7;
  localparam int WSGL_BIT = 9;

  typedef struct packed {
    logic       full;       // full-page burst
    logic [2:0] blk_mask;   // burst length minus one for fixed bursts
    logic       wr_single;  // writes are single-location
    logic [1:0] cas;        // read latency 1..3
  } sdb_mode_t;

endpackage

// File: rtl/sdb_mode_reg.sv
module sdb_mode_reg
  import sdb_pkg::*;
#(
  parameter int          MODE_W   = 12,
  parameter logic [11:0] RST_MODE = 12'h030
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [MODE_W-1:0] word_i,
  output sdb_mode_t         mode_o,
  output logic              reserved_o
);

  logic [MODE_W-1:0] word_q, word_d;
  logic [2:0]        bl_code, cl_code;
  logic [1:0]        opm_code;
  logic              bl_rsv, cl_rsv;
  logic              unused_bits;

  always_comb begin
    word_d = word_q;
    if (load_i) word_d = word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= MODE_W'(RST_MODE);
    else        word_q <= word_d;
  end

  assign bl_code  = word_q[BL_LSB+2:BL_LSB];
  assign cl_code  = word_q[CL_LSB+2:CL_LSB];
  assign opm_code = word_q[OPM_LSB+1:OPM_LSB];
  assign unused_bits = ^{word_q[MODE_W-1:WSGL_BIT+1], word_q[3]};

  always_comb begin
    mode_o.full     = 1'b0;
    mode_o.blk_mask = 3'd0;
    bl_rsv          = 1'b0;
    case (bl_code)
      3'd0:    mode_o.blk_mask = 3'd0;
      3'd1:    mode_o.blk_mask = 3'd1;
      3'd2:    mode_o.blk_mask = 3'd3;
      3'd3:    mode_o.blk_mask = 3'd7;
      3'd7:    mode_o.full     = 1'b1;
      default: bl_rsv          = 1'b1;
    endcase
  end

  always_comb begin
    cl_rsv     = 1'b0;
    mode_o.cas = 2'd3;
    case (cl_code)
      3'd1:    mode_o.cas = 2'd1;
      3'd2:    mode_o.cas = 2'd2;
      3'd3:    mode_o.cas = 2'd3;
      default: cl_rsv     = 1'b1;
    endcase
  end

  assign mode_o.wr_single = word_q[WSGL_BIT];
  assign reserved_o       = bl_rsv | cl_rsv | (opm_code != 2'b00);

  // R6
  opmode_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (word_i[OPM_LSB+1:OPM_LSB] != 2'b00)) |=> reserved_o);

endmodule

// File: rtl/sdb_col_ctr.sv
module sdb_col_ctr
  import sdb_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rd_i,
  input  logic             start_wr_i,
  input  logic [COL_W-1:0] start_col_i,
  input  sdb_mode_t        mode_i,
  output logic             busy_o,
  output logic             is_rd_o,
  output logic [COL_W-1:0] col_o
);

  localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

  logic             busy_q, busy_d;
  logic             rd_q, rd_d;
  logic             full_q, full_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic [2:0]       rem_q, rem_d;
  logic             start, single_wr;
  logic [COL_W-1:0] col_adv;
  logic [COL_W-1:0] col_inc;

  assign start     = start_rd_i | start_wr_i;
  assign single_wr = start_wr_i & mode_i.wr_single;
  assign col_inc   = col_q + COL_W'(1);
  assign col_adv   = (col_q & ~mask_q) | (col_inc & mask_q);

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    full_d = full_q;
    col_d  = col_q;
    mask_d = mask_q;
    rem_d  = rem_q;
    if (start) begin
      busy_d = 1'b1;
      rd_d   = start_rd_i;
      col_d  = start_col_i;
      full_d = mode_i.full & ~single_wr;
      if (single_wr) begin
        mask_d = '0;
        rem_d  = 3'd0;
      end else if (mode_i.full) begin
        mask_d = PAGE_MASK;
        rem_d  = 3'd0;
      end else begin
        mask_d = {{(COL_W-3){1'b0}}, mode_i.blk_mask};
        rem_d  = mode_i.blk_mask;
      end
    end else if (busy_q) begin
      if (full_q) begin
        col_d = col_adv;
      end else if (rem_q == 3'd0) begin
        busy_d = 1'b0;
      end else begin
        rem_d = rem_q - 3'd1;
        col_d = col_adv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      full_q <= 1'b0;
      col_q  <= '0;
      mask_q <= '0;
      rem_q  <= 3'd0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      full_q <= full_d;
      col_q  <= col_d;
      mask_q <= mask_d;
      rem_q  <= rem_d;
    end
  end

  assign busy_o  = busy_q;
  assign is_rd_o = rd_q;
  assign col_o   = col_q;

  // R3
  wrap_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(start)) |->
      (((col_q ^ $past(col_q)) & ~mask_q) == '0));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && (col_q == $past(start_col_i))));

  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_wr ##1 !start) |=> !busy_q);

endmodule

// File: rtl/sdb_lat_pipe.sv
module sdb_lat_pipe #(
  parameter int DATA_W = 32,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v_i,
  input  logic [DATA_W-1:0] in_d_i,
  input  logic [1:0]        cas_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              oe_o,
  output logic              out_v_o
);

  logic [MAX_CL:0]   v_ext;
  logic [DATA_W-1:0] d_ext [MAX_CL+1];
  logic [1:0]        cas_m1;

  assign v_ext[0] = in_v_i;
  assign d_ext[0] = in_d_i;

  for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
    logic              v_q;
    logic [DATA_W-1:0] d_q, d_d;

    always_comb begin
      d_d = d_q;
      if (v_ext[g]) d_d = d_ext[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= v_ext[g];
        d_q <= d_d;
      end
    end

    assign v_ext[g+1] = v_q;
    assign d_ext[g+1] = d_q;
  end

  assign cas_m1  = cas_i - 2'd1;
  assign out_v_o = v_ext[cas_i];
  assign oe_o    = v_ext[cas_m1] | v_ext[cas_i];
  assign dq_o    = out_v_o ? d_ext[cas_i] : '0;

endmodule

// File: rtl/sdb_engine.sv
module sdb_engine
  import sdb_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int DATA_W = 32,
  parameter int MODE_W = 12,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [MODE_W-1:0] mode_word,
  output logic [COL_W-1:0]  arr_addr,
  output logic              arr_we,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              col_busy,
  output logic              mode_reserved
);

  sdb_cmd_e          cmd_e;
  sdb_mode_t         mode;
  logic              is_rd;
  logic              wd_en;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              dq_valid;

  assign cmd_e = sdb_cmd_e'(cmd);

  sdb_mode_reg #(.MODE_W(MODE_W)) i_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cmd_e == CMD_MODE),
    .word_i     (mode_word),
    .mode_o     (mode),
    .reserved_o (mode_reserved)
  );

  sdb_col_ctr #(.COL_W(COL_W)) i_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_rd_i  (cmd_e == CMD_READ),
    .start_wr_i  (cmd_e == CMD_WRITE),
    .start_col_i (cmd_col),
    .mode_i      (mode),
    .busy_o      (col_busy),
    .is_rd_o     (is_rd),
    .col_o       (arr_addr)
  );

  // Write data is captured at the edge that opens each write beat
  assign wd_en = (cmd_e == CMD_WRITE) | (col_busy & ~is_rd);

  always_comb begin
    wd_d = wd_q;
    if (wd_en) wd_d = dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_q <= '0;
    else        wd_q <= wd_d;
  end

  assign arr_we    = col_busy & ~is_rd;
  assign arr_wdata = wd_q;

  sdb_lat_pipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL)) i_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_v_i  (col_busy & is_rd),
    .in_d_i  (arr_rdata),
    .cas_i   (mode.cas),
    .dq_o    (dq_out),
    .oe_o    (dq_oe),
    .out_v_o (dq_valid)
  );

  // R8
  oe_leads_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> $past(dq_oe));

endmodule

// File: tb/test_sdb_engine.sv
module test_sdb_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cmd;
  logic [8:0]  cmd_col;
  logic [11:0] mode_word;
  logic [8:0]  arr_addr;
  logic        arr_we;
  logic [31:0] arr_wdata;
  logic [31:0] arr_rdata;
  logic [31:0] dq_in;
  logic [31:0] dq_out;
  logic        dq_oe;
  logic        col_busy;
  logic        mode_reserved;

  always #10 clk = ~clk;

  sdb_engine i_sdb_engine (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_col(cmd_col),
    .mode_word(mode_word), .arr_addr(arr_addr), .arr_we(arr_we),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .col_busy(col_busy),
    .mode_reserved(mode_reserved)
  );

  // Bench-owned array
  logic [31:0] bmem [512];
  assign arr_rdata = bmem[arr_addr];
  always @(posedge clk) if (arr_we) bmem[arr_addr] <= arr_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  logic [31:0] m_mem [512];
  bit   m_busy, m_rd, m_rsv, m_ws;
  int   m_col, m_len, m_pos, m_bl, m_cl;
  logic [31:0] m_wd;
  bit          exp_v  [4096];
  bit          exp_oe [4096];
  logic [31:0] exp_d  [4096];
  int t = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h edge=%0d", tag, act, exp, t);
    end
  endtask

  task automatic decode(input logic [11:0] w);
    m_rsv = 0;
    case (w[2:0])
      3'd0: m_bl = 1;
      3'd1: m_bl = 2;
      3'd2: m_bl = 4;
      3'd3: m_bl = 8;
      3'd7: m_bl = 512;
      default: begin m_bl = 1; m_rsv = 1; end
    endcase
    if (w[6:4] >= 3'd1 && w[6:4] <= 3'd3) m_cl = int'(w[6:4]);
    else begin m_cl = 3; m_rsv = 1; end
    if (w[8:7] != 2'b00) m_rsv = 1;
    m_ws = w[9];
  endtask

  task automatic model_step(input logic [1:0] c, input int col, input logic [11:0] w, input logic [31:0] din);
    if (m_busy && !m_rd) m_mem[m_col] = m_wd;
    m_wd = din;
    if (c == 2'd1 || c == 2'd2) begin
      m_len  = (c == 2'd2 && m_ws) ? 1 : m_bl;
      m_busy = 1;
      m_rd   = (c == 2'd1);
      m_col  = col;
      m_pos  = 0;
    end else if (m_busy) begin
      m_pos++;
      if (m_len != 512 && m_pos == m_len) m_busy = 0;
      else m_col = (m_col / m_len) * m_len + ((m_col + 1) % m_len);
    end
    if (c == 2'd3) decode(w);
    if (m_busy && m_rd) begin
      exp_v[t + m_cl]      = 1;
      exp_d[t + m_cl]      = m_mem[m_col];
      exp_oe[t + m_cl - 1] = 1;
      exp_oe[t + m_cl]     = 1;
    end
  endtask

  task automatic compare();
    chk("R2/R3/R4/R5/R9 busy", {31'd0, col_busy}, {31'd0, m_busy});
    if (m_busy) chk("R2/R3/R4/R9 column", {23'd0, arr_addr}, m_col[31:0]);
    chk("R5/R10 write strobe", {31'd0, arr_we}, {31'd0, m_busy && !m_rd});
    if (m_busy && !m_rd) chk("R10 write data", arr_wdata, m_wd);
    chk("R8 output enable", {31'd0, dq_oe}, {31'd0, exp_oe[t]});
    chk("R7/R11 read data", dq_out, exp_v[t] ? exp_d[t] : 32'd0);
    chk("R6 reserved flag", {31'd0, mode_reserved}, {31'd0, m_rsv});
  endtask

  task automatic cyc(input logic [1:0] c, input int col, input logic [11:0] w, input logic [31:0] din);
    cmd = c; cmd_col = col[8:0]; mode_word = w; dq_in = din;
    @(posedge clk);
    #1;
    model_step(c, col, w, din);
    @(negedge clk);
    compare();
    t++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(2'd0, 0, 12'h000, 32'h0);
  endtask

  task automatic load(input logic [11:0] w);
    cyc(2'd3, 0, w, 32'h0);
    idle(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      bmem[i]  = (i * 32'h9E3779B1) ^ 32'h0F0F0000;
      m_mem[i] = (i * 32'h9E3779B1) ^ 32'h0F0F0000;
    end
    for (int i = 0; i < 4096; i++) begin
      exp_v[i] = 0; exp_oe[i] = 0; exp_d[i] = '0;
    end
    m_busy = 0; m_rd = 0; m_wd = '0; m_col = 0; m_len = 1; m_pos = 0;
    decode(12'h030);
    rst_n = 1'b0; cmd = 2'd0; cmd_col = '0; mode_word = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy at reset", {31'd0, col_busy}, 32'd0);
    chk("R1 oe at reset", {31'd0, dq_oe}, 32'd0);
    chk("R1 dq at reset", dq_out, 32'd0);
    chk("R1 reserved at reset", {31'd0, mode_reserved}, 32'd0);
    rst_n = 1'b1;

    // R1 default mode: length 1, latency 3
    cyc(2'd1, 5, 12'h000, 32'h0); idle(6);
    // R3 length 4, latency 2, wrap inside block
    load(12'h022);
    cyc(2'd1, 6, 12'h000, 32'h0); idle(6);
    // R10 write burst then read back
    for (int i = 0; i < 4; i++)
      cyc(i == 0 ? 2'd2 : 2'd0, 13, 12'h000, 32'hC0DE0000 + i);
    idle(2);
    cyc(2'd1, 12, 12'h000, 32'h0); idle(6);
    // R7 R9 length 8, latency 1, back-to-back reads
    load(12'h013);
    cyc(2'd1, 3, 12'h000, 32'h0); idle(9);
    cyc(2'd1, 10, 12'h000, 32'h0);
    cyc(2'd1, 20, 12'h000, 32'h0);
    cyc(2'd1, 30, 12'h000, 32'h0); idle(10);
    // R2 length 2, latency 3
    load(12'h031);
    cyc(2'd1, 9, 12'h000, 32'h0); idle(6);
    // R4 full page, latency 2, wrap past 511 and interruption
    load(12'h027);
    cyc(2'd1, 508, 12'h000, 32'h0); idle(8);
    cyc(2'd1, 100, 12'h000, 32'h0); idle(4);
    cyc(2'd2, 200, 12'h000, 32'h11110000);
    for (int i = 1; i < 6; i++) cyc(2'd0, 0, 12'h000, 32'h11110000 + i);
    cyc(2'd3, 0, 12'h227, 32'h2222);
    cyc(2'd0, 0, 12'h000, 32'h3333);
    cyc(2'd2, 60, 12'h000, 32'h44444444); idle(3);
    // R5 single-location write with bursting reads
    load(12'h222);
    cyc(2'd2, 40, 12'h000, 32'hBEEF0040); idle(2);
    cyc(2'd1, 40, 12'h000, 32'h0); idle(6);
    // R6 reserved words
    load(12'h1D5);
    cyc(2'd1, 77, 12'h000, 32'h0); idle(6);
    load(12'h032);
    load(12'h192);
    cyc(2'd1, 50, 12'h000, 32'h0); idle(6);
    load(12'h022);
    idle(3);
    finish_run();
  end

endmodule